// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by walking a context table and up to three levels of page tables. The tables live in a memory reached through a request/acknowledge port, used for descriptor reads and for writing updated page table entries back. The walk ends at the first level that holds a page table entry, so one translation can map 16 MB, 256 KB or 4 KB. Each entry carries a 3-bit permission field. The walker checks that field against the kind of access and the privilege of the requester. It also updates the entry's referenced and modified flags.

A requester presents the address, the access kind (write, fetch, supervisor) and a one-cycle `req_valid` while the walker is idle. The walker answers with a one-cycle `done`. At that point `xlat_ok`, `pa` and `wr_ok` hold the result. A failed walk is logged in a fault status byte and a fault address word, and it raises `trap` unless fault reporting is suppressed. With translation disabled, the address passes straight through and no memory access is made.

Top module: `pgw_top`

## Requirements
- R1: With `cfg_enable` low, a request finishes with `pa` equal to the zero-extended virtual address, `wr_ok` high and `xlat_ok` high, makes no memory access, and leaves the fault registers untouched.
- R2: The first read goes to `({cfg_ctx_ptr,4'h0}) + (cfg_ctx_num << 4)`. Descriptor bits 1:0 encode the type: 0 invalid, 1 table pointer, 2 page entry, 3 reserved. A table pointer leads to `({desc[31:2],2'b00} << 4) + 4*index`, where the index is VA[31:24] after the context entry, VA[23:18] after level 1 and VA[17:12] after level 2.
- R3: A page entry found at level 1, 2 or 3 yields `pa = {pte[31:8],12'h000} + offset`, where the offset is VA[23:0], VA[17:0] or VA[11:0] respectively.
- R4: An invalid descriptor fails with fault type 1. A reserved descriptor, a page entry in the context table, or a table pointer at level 3 fails with fault type 4. No write is made after a descriptor fault.
- R5: Entry bit 5 is the referenced flag and bit 6 the modified flag. The entry is written back once, at its own address, when bit 5 is clear or when a write finds bit 6 clear. The written value has bit 5 set, and bit 6 also set on a write. Otherwise no write occurs.
- R6: The access index is `{write, fetch, supervisor}`. With permission field pte[4:2] = p, a user access with p of 6 or 7 fails with type 3. Otherwise the access fails with type 2 in three cases: a write without write right, a fetch without execute right, or a plain read without read right. The rights are: user read p in {0,1,2,3,5}; supervisor read any p except 4; user execute {2,3,4}; supervisor execute {2,3,4,6,7}; user write {1,3}; supervisor write any odd p.
- R7: `wr_ok` is high only for a successful walk whose final entry has the modified flag set and whose p grants write in the requester's mode. User mode needs p of 1 or 3; supervisor mode needs any odd p.
- R8: On every fault, the fault status byte is rebuilt. Bit 0 is 1 if the byte was non-zero before. Bit 1 is 1. Bits 4:2 hold the fault type and bits 7:5 the access index. The fault address word takes the virtual address. Both are visible from the cycle after `done`.
- R9: `trap` pulses with `done` on a fault only when `cfg_nofault` is low and `cfg_traps_en` is high. The fault registers update either way.
- R10: Each memory access holds `mem_req` and a stable `mem_addr` until `mem_ack`. A walk that stops at level L (context = 0) makes exactly L+1 reads.
- R11: Every accepted request ends with `done` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a translation (sampled when idle) |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_super | input | 1 | Requester is in supervisor mode |
| cfg_enable | input | 1 | Translation enabled |
| cfg_nofault | input | 1 | Suppress trap on fault |
| cfg_traps_en | input | 1 | Traps enabled |
| cfg_ctx_ptr | input | 32 | Context table pointer |
| cfg_ctx_num | input | CTX_W | Context number |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | 36 | Byte address of the descriptor |
| mem_wdata | output | 32 | Updated page entry |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Descriptor read data |
| done | output | 1 | Walk finished (one cycle) |
| xlat_ok | output | 1 | Walk finished without fault |
| trap | output | 1 | Fault to be reported as an exception |
| pa | output | 36 | Physical address |
| wr_ok | output | 1 | Writes may use this mapping |
| fsr | output | 8 | Fault status byte |
| far | output | 32 | Fault address |

## Verification
The hardest cases to reach from the ports need the memory image prepared and the walk's own side effects taken into account. These cases are the write-back decision, crossed with every permission value, every access index and every terminal level, and the overflow bit, which depends on the whole history of faults. The bench rebuilds a descriptor chain for each walk in its memory model, with the flags and permission chosen by a sweep. It then checks the final memory word, the number of reads and writes, and the status byte. A running model of the status byte carries the overflow behaviour from one fault to the next.

// File: rtl/pgw_pkg.sv
// Shared constants for the page table walker.
// Assumes 32-bit descriptors and a 36-bit physical address space.
package pgw_pkg;
    localparam int VA_W    = 32;
    localparam int PA_W    = 36;
    localparam int DESC_W  = 32;
    localparam int FSR_W   = 8;
    localparam int BIT_REF = 5;
    localparam int BIT_MOD = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CHECK,
        ST_WBACK,
        ST_FIN
    } walk_st_t;

    localparam logic [1:0] DT_INVALID = 2'd0;
    localparam logic [1:0] DT_PTD     = 2'd1;
    localparam logic [1:0] DT_PTE     = 2'd2;

    localparam logic [2:0] FT_NONE    = 3'd0;
    localparam logic [2:0] FT_INVALID = 3'd1;
    localparam logic [2:0] FT_PROT    = 3'd2;
    localparam logic [2:0] FT_PRIV    = 3'd3;
    localparam logic [2:0] FT_TRANS   = 3'd4;
endpackage

// File: rtl/pgw_perm.sv
// Permission decoder: maps a 3-bit entry permission and the access kind
// to a fault type, and says whether writes may be granted.
// Assumes purely combinational use; no state.
module pgw_perm
    import pgw_pkg::*;
(
    input  logic [2:0] acc_field,
    input  logic       is_write,
    input  logic       is_fetch,
    input  logic       is_super,
    input  logic       modified,
    output logic [2:0] fcode,
    output logic       wr_grant
);
    logic rd_right;
    logic ex_right;
    logic wr_right;

    // Derive per-mode rights, then the fault type.
    always_comb begin
        rd_right = is_super ? (acc_field != 3'd4)
                            : (acc_field <= 3'd3 || acc_field == 3'd5);
        ex_right = is_super ? (acc_field inside {3'd2, 3'd3, 3'd4, 3'd6, 3'd7})
                            : (acc_field inside {3'd2, 3'd3, 3'd4});
        wr_right = is_super ? acc_field[0] : (acc_field[0] && !acc_field[2]);
        if (!is_super && acc_field[2:1] == 2'b11)
            fcode = FT_PRIV;
        else if ((is_write && !wr_right) || (is_fetch && !ex_right) ||
                 (!is_write && !is_fetch && !rd_right))
            fcode = FT_PROT;
        else
            fcode = FT_NONE;
        wr_grant = modified && wr_right;
    end
endmodule

// File: rtl/pgw_flog.sv
// Fault log: fault status byte with overflow flag and fault address word.
// Assumes evt is a single-cycle pulse at the end of a failed walk.
module pgw_flog
    import pgw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic [2:0]       aidx,
    input  logic [2:0]       ftype,
    input  logic [VA_W-1:0]  va,
    output logic [FSR_W-1:0] fsr,
    output logic [VA_W-1:0]  far
);
    // Record a fault, marking overflow if the previous one is still present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsr <= '0;
            far <= '0;
        end else if (evt) begin
            fsr <= ((fsr != '0) ? FSR_W'(1) : FSR_W'(0)) |
                   FSR_W'({aidx, ftype, 2'b10});
            far <= va;
        end
    end

    AST_FSR_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> fsr[1]); // R8
    AST_FAR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> far == $past(va)); // R8
    AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && fsr != '0) |=> fsr[0]); // R8
    AST_FSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(fsr)); // R8
endmodule

// File: rtl/pgw_top.sv
// Page table walker top: context table plus three table levels, stopping at
// the first page entry. Updates referenced/modified flags, checks permissions
// and logs faults. Assumes one outstanding memory access and that requests
// are only raised while done/busy sequencing has returned to idle.
module pgw_top
    import pgw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic              req_super,
    input  logic              cfg_enable,
    input  logic              cfg_nofault,
    input  logic              cfg_traps_en,
    input  logic [VA_W-1:0]   cfg_ctx_ptr,
    input  logic [CTX_W-1:0]  cfg_ctx_num,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [DESC_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DESC_W-1:0] mem_rdata,
    output logic              done,
    output logic              xlat_ok,
    output logic              trap,
    output logic [PA_W-1:0]   pa,
    output logic              wr_ok,
    output logic [FSR_W-1:0]  fsr,
    output logic [VA_W-1:0]   far
);
    localparam logic [1:0] LAST_LVL = 2'd3;

    walk_st_t          st;
    logic [1:0]        lvl;
    logic [VA_W-1:0]   va;
    logic [2:0]        aidx;
    logic [PA_W-1:0]   cur_addr;
    logic [DESC_W-1:0] pte;
    logic              flt;
    logic [2:0]        ftype;
    logic [PA_W-1:0]   pa_q;
    logic              wr_ok_q;

    logic [PA_W-1:0]   ctx_addr;
    logic [PA_W-1:0]   next_base;
    logic [PA_W-1:0]   next_idx;
    logic [PA_W-1:0]   pte_base;
    logic [PA_W-1:0]   pg_off;
    logic [DESC_W-1:0] pte_upd;
    logic              need_wb;
    logic [2:0]        pcode;
    logic              pgrant;

    // Address arithmetic and flag-update values for the current step.
    always_comb begin
        ctx_addr  = {cfg_ctx_ptr, 4'h0} + (PA_W'(cfg_ctx_num) << 4);
        next_base = {mem_rdata[DESC_W-1:2], 2'b00, 4'h0};
        case (lvl)
            2'd0:    next_idx = PA_W'({va[31:24], 2'b00});
            2'd1:    next_idx = PA_W'({va[23:18], 2'b00});
            default: next_idx = PA_W'({va[17:12], 2'b00});
        endcase
        case (lvl)
            2'd1:    pg_off = PA_W'(va[23:0]);
            2'd2:    pg_off = PA_W'(va[17:0]);
            default: pg_off = PA_W'(va[11:0]);
        endcase
        pte_base = {pte[DESC_W-1:8], 12'h000};
        pte_upd  = pte | (DESC_W'(1) << BIT_REF) |
                   (aidx[2] ? (DESC_W'(1) << BIT_MOD) : '0);
        need_wb  = !pte[BIT_REF] || (aidx[2] && !pte[BIT_MOD]);
    end

    pgw_perm u_perm (
        .acc_field (pte_upd[4:2]),
        .is_write  (aidx[2]),
        .is_fetch  (aidx[1]),
        .is_super  (aidx[0]),
        .modified  (pte_upd[BIT_MOD]),
        .fcode     (pcode),
        .wr_grant  (pgrant)
    );

    // Walk sequencer: accept, read descriptors, check, write back, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            lvl      <= 2'd0;
            va       <= '0;
            aidx     <= 3'd0;
            cur_addr <= '0;
            pte      <= '0;
            flt      <= 1'b0;
            ftype    <= FT_NONE;
            pa_q     <= '0;
            wr_ok_q  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    va    <= req_vaddr;
                    aidx  <= {req_write, req_fetch, req_super};
                    flt   <= 1'b0;
                    ftype <= FT_NONE;
                    lvl   <= 2'd0;
                    if (!cfg_enable) begin
                        pa_q    <= PA_W'(req_vaddr);
                        wr_ok_q <= 1'b1;
                        st      <= ST_FIN;
                    end else begin
                        cur_addr <= ctx_addr;
                        wr_ok_q  <= 1'b0;
                        st       <= ST_READ;
                    end
                end
                ST_READ: if (mem_ack) begin
                    if (mem_rdata[1:0] == DT_PTD && lvl != LAST_LVL) begin
                        cur_addr <= next_base + next_idx;
                        lvl      <= lvl + 2'd1;
                    end else if (mem_rdata[1:0] == DT_PTE && lvl != 2'd0) begin
                        pte <= mem_rdata;
                        st  <= ST_CHECK;
                    end else begin
                        flt   <= 1'b1;
                        ftype <= (mem_rdata[1:0] == DT_INVALID) ? FT_INVALID : FT_TRANS;
                        st    <= ST_FIN;
                    end
                end
                ST_CHECK: begin
                    pte     <= pte_upd;
                    pa_q    <= pte_base + pg_off;
                    flt     <= (pcode != FT_NONE);
                    ftype   <= pcode;
                    wr_ok_q <= (pcode == FT_NONE) && pgrant;
                    st      <= need_wb ? ST_WBACK : ST_FIN;
                end
                ST_WBACK: if (mem_ack) st <= ST_FIN;
                ST_FIN:   st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // Port drive from sequencer state.
    always_comb begin
        mem_req   = (st == ST_READ) || (st == ST_WBACK);
        mem_we    = (st == ST_WBACK);
        mem_addr  = cur_addr;
        mem_wdata = pte;
        done      = (st == ST_FIN);
        xlat_ok   = done && !flt;
        trap      = done && flt && !cfg_nofault && cfg_traps_en;
        pa        = pa_q;
        wr_ok     = wr_ok_q;
    end

    pgw_flog u_flog (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (done && flt),
        .aidx  (aidx),
        .ftype (ftype),
        .va    (va),
        .fsr   (fsr),
        .far   (far)
    );

    AST_BYPASS_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && req_valid && !cfg_enable) |=> (done && !mem_req)); // R1
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_WB_MARKS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[BIT_REF]); // R5
    AST_TRAP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (done && !xlat_ok)); // R9
endmodule

// File: tb/test_pgw_top.sv
`timescale 1ns/1ps
module test_pgw_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0, req_fetch = 1'b0, req_super = 1'b0;
    logic        cfg_enable = 1'b0, cfg_nofault = 1'b0, cfg_traps_en = 1'b1;
    logic [31:0] cfg_ctx_ptr = 32'h10;
    logic [7:0]  cfg_ctx_num = 8'd3;
    logic        mem_req, mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, xlat_ok, trap, wr_ok;
    logic [35:0] pa;
    logic [7:0]  fsr;
    logic [31:0] far;

    always #2 clk = ~clk;

    pgw_top #(.CTX_W(8)) i_pgw_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_fetch(req_fetch), .req_super(req_super),
        .cfg_enable(cfg_enable), .cfg_nofault(cfg_nofault), .cfg_traps_en(cfg_traps_en),
        .cfg_ctx_ptr(cfg_ctx_ptr), .cfg_ctx_num(cfg_ctx_num),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .xlat_ok(xlat_ok),
        .trap(trap), .pa(pa), .wr_ok(wr_ok), .fsr(fsr), .far(far)
    );

    // Expected fault type by [access index][permission].
    localparam int EXP_TBL [8][8] = '{
        '{0,0,0,0,2,0,3,3}, '{0,0,0,0,2,0,0,0},
        '{2,2,0,0,0,2,3,3}, '{2,2,0,0,0,2,0,0},
        '{2,0,2,0,2,2,3,3}, '{2,0,2,0,2,0,2,0},
        '{2,2,2,0,2,2,3,3}, '{2,2,2,0,2,2,2,0}
    };

    logic [31:0] mem [0:2047];
    int rd_cnt = 0, wr_cnt = 0;
    int n_chk = 0, n_err = 0;
    logic [7:0] exp_fsr = 8'h00;
    logic [35:0] last_addr;

    // Memory model: one-cycle acknowledge per access.
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[12:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[12:2]];
                rd_cnt <= rd_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [35:0] s_pa;
    logic s_ok, s_trap, s_wr_ok, s_pulse;
    int s_rd, s_wr;

    task automatic walk(input logic [31:0] v, input logic [2:0] ax);
        int rd0;
        int wr0;
        int t;
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        t = 0;
        @(negedge clk);
        req_vaddr = v;
        {req_write, req_fetch, req_super} = ax;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && t < 100) begin
            @(negedge clk);
            t++;
        end
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R11: walk never finished actual=0 expected=1");
        end
        s_pa = pa; s_ok = xlat_ok; s_trap = trap; s_wr_ok = wr_ok;
        @(negedge clk);
        s_pulse = done;
        s_rd = rd_cnt - rd0;
        s_wr = wr_cnt - wr0;
    endtask

    // Build a chain ending with 'last' at level stop_lv (0 = context table).
    task automatic setup_chain(input logic [31:0] v, input int stop_lv, input logic [31:0] last);
        logic [35:0] a;
        a = {cfg_ctx_ptr, 4'h0} + (36'(cfg_ctx_num) << 4);
        mem[a[12:2]] = (stop_lv == 0) ? last : 32'h41;
        last_addr = a;
        if (stop_lv >= 1) begin
            a = 36'h400 + {26'h0, v[31:24], 2'b00};
            mem[a[12:2]] = (stop_lv == 1) ? last : 32'h81;
            last_addr = a;
        end
        if (stop_lv >= 2) begin
            a = 36'h800 + {28'h0, v[23:18], 2'b00};
            mem[a[12:2]] = (stop_lv == 2) ? last : 32'hA1;
            last_addr = a;
        end
        if (stop_lv >= 3) begin
            a = 36'hA00 + {28'h0, v[17:12], 2'b00};
            mem[a[12:2]] = last;
            last_addr = a;
        end
    endtask

    function automatic logic [7:0] next_fsr(input logic [7:0] cur, input logic [2:0] ax,
                                            input logic [2:0] code);
        return ((cur != 8'h00) ? 8'h01 : 8'h00) | {ax, code, 2'b10};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk("R11 reset done", {63'h0, done}, 64'h0);
        chk("R10 reset mem_req", {63'h0, mem_req}, 64'h0);
        chk("R8 reset fsr", {56'h0, fsr}, 64'h0);
        chk("R8 reset far", {32'h0, far}, 64'h0);

        // R1: pass-through when translation is off
        cfg_enable = 1'b0;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] v;
            v = (k == 0) ? 32'h0 : (k == 1) ? 32'hFFFF_FFFF : 32'h1234_5678 * k;
            walk(v, 3'(k * 3));
            chk("R1 pa", {28'h0, s_pa}, {32'h0, v});
            chk("R1 wr_ok", {63'h0, s_wr_ok}, 64'h1);
            chk("R1 ok", {63'h0, s_ok}, 64'h1);
            chk("R1 reads", 64'(s_rd + s_wr), 64'h0);
            chk("R11 pulse", {63'h0, s_pulse}, 64'h0);
            chk("R1 fsr untouched", {56'h0, fsr}, 64'h0);
        end

        // R4: descriptor faults at every level
        cfg_enable = 1'b1;
        for (int lv = 0; lv < 4; lv++) begin
            for (int dt = 0; dt < 4; dt++) begin
                logic [31:0] v;
                logic [2:0] ax;
                logic [2:0] code;
                if ((lv == 0 && dt == 1) || ((lv == 1 || lv == 2) && dt != 0 && dt != 3) ||
                    (lv == 3 && dt == 2)) continue;
                v = 32'h9C4E_7123 + 32'(lv) * 32'h0104_1000 + 32'(dt) * 32'h2208_3000;
                ax = 3'((lv * 4 + dt) % 8);
                code = (dt == 0) ? 3'd1 : 3'd4;
                setup_chain(v, lv, 32'hABCD_E000 | 32'(dt));
                walk(v, ax);
                exp_fsr = next_fsr(exp_fsr, ax, code);
                chk("R4 not ok", {63'h0, s_ok}, 64'h0);
                chk("R4 no write", 64'(s_wr), 64'h0);
                chk("R10 reads", 64'(s_rd), 64'(lv + 1));
                chk("R8 fsr", {56'h0, fsr}, {56'h0, exp_fsr});
                chk("R8 far", {32'h0, far}, {32'h0, v});
                chk("R9 trap", {63'h0, s_trap}, 64'h1);
                chk("R11 pulse", {63'h0, s_pulse}, 64'h0);
            end
        end
        chk("R8 overflow flag after repeated faults", {63'h0, fsr[0]}, 64'h1);

        // R2/R3/R5/R6/R7/R8/R9: sweep over level, permission, access, flags
        for (int lv = 1; lv <= 3; lv++) begin
            cfg_ctx_ptr = (lv == 2) ? 32'h0C : 32'h10;
            cfg_ctx_num = (lv == 2) ? 8'd5 : 8'd3;
            for (int pm = 0; pm < 8; pm++) begin
                for (int ax = 0; ax < 8; ax++) begin
                    for (int rm = 0; rm < 4; rm++) begin
                        logic [31:0] v, pte, wpte;
                        logic [35:0] epa, off;
                        logic wr, sup, needwb, mfin, wmode, ewr, etrap;
                        int ft;
                        v = 32'(pm) * 32'h1F3A_2B17 + 32'(ax) * 32'h0D41_C3A5 +
                            32'(rm) * 32'h2468_ACE1 + 32'(lv) * 32'h1357_9BDF;
                        pte = {v[23:0] ^ 24'h5A5A5, 1'b0, rm[1], rm[0], 3'(pm), 2'b10};
                        wr = ax[2];
                        sup = ax[0];
                        cfg_nofault = (ax == 3 && pm > 4);
                        cfg_traps_en = !(lv == 3 && rm == 2);
                        setup_chain(v, lv, pte);
                        walk(v, 3'(ax));
                        ft = EXP_TBL[ax][pm];
                        needwb = !pte[5] || (wr && !pte[6]);
                        wpte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
                        mfin = pte[6] | wr;
                        wmode = sup ? pte[2] : (pte[2] && !pte[4]);
                        ewr = (ft == 0) && mfin && wmode;
                        off = (lv == 1) ? {12'h0, v[23:0]} : (lv == 2) ? {18'h0, v[17:0]} :
                              {24'h0, v[11:0]};
                        epa = {pte[31:8], 12'h000} + off;
                        chk("R10 reads", 64'(s_rd), 64'(lv + 1));
                        chk("R5 write count", 64'(s_wr), needwb ? 64'h1 : 64'h0);
                        chk("R5 entry value", {32'h0, mem[last_addr[12:2]]},
                            {32'h0, needwb ? wpte : pte});
                        chk("R6 outcome", {63'h0, s_ok}, (ft == 0) ? 64'h1 : 64'h0);
                        chk("R7 wr_ok", {63'h0, s_wr_ok}, {63'h0, ewr});
                        chk("R11 pulse", {63'h0, s_pulse}, 64'h0);
                        if (ft == 0) begin
                            chk("R3 pa", {28'h0, s_pa}, {28'h0, epa});
                            chk("R9 no trap", {63'h0, s_trap}, 64'h0);
                        end else begin
                            exp_fsr = next_fsr(exp_fsr, 3'(ax), 3'(ft));
                            etrap = !cfg_nofault && cfg_traps_en;
                            chk("R8 fsr", {56'h0, fsr}, {56'h0, exp_fsr});
                            chk("R8 far", {32'h0, far}, {32'h0, v});
                            chk("R9 trap", {63'h0, s_trap}, {63'h0, etrap});
                        end
                    end
                end
            end
            chk("R2 context entry used", {63'h0, s_rd == lv + 1}, 64'h1);
        end

        // R8: first fault after reset carries no overflow
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cfg_nofault = 1'b0;
        cfg_traps_en = 1'b1;
        setup_chain(32'h0300_0000, 1, 32'h0000_0000);
        walk(32'h0300_0000, 3'd1);
        chk("R8 first fault", {56'h0, fsr}, {56'h0, 8'h26});
        walk(32'h0300_0000, 3'd4);
        chk("R8 second fault overflow", {56'h0, fsr}, {56'h0, 8'h87});

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule